// File: doc/BRIEF.md
# Center-Aligned Complementary PWM with Dead Time and Break

This block produces three pairs of complementary PWM outputs from one shared triangle counter. The counter climbs from zero to the period value less one and then falls back to zero. Each channel compares the counter against its own threshold to form an internal reference waveform. From that reference the block drives a high-side output and a low-side output. Each side turns on only after a programmable guard interval following a reference transition, so the two sides of a pair are never on together.

A shutdown input with selectable polarity forces all six outputs low without waiting for a clock edge. It also clears the output-enable bit, so the outputs stay off until software enables them again after the shutdown input has been released. A set-only lock bit freezes the guard interval and the shutdown settings. The period and the thresholds stay writable while the lock is set. All configuration goes through one write port: a 3-bit address and a data word.

Top module: `cpwm_deadband`

## Requirements
- R1: The counter runs 0,1,…,P−1,P−1,…,1,0 and repeats every 2P cycles, where P is the period written at address 0. The reference of channel i (threshold at address 1+i) is high while the counter is below the threshold. It is therefore high for 2C consecutive cycles per period when 0<C<P, always low when C=0 and always high when C≥P.
- R2: The guard interval D is written at address 4 in clock cycles. Over one period, channel i's high output is on for max(0, 2C−D) cycles and its low output for max(0, 2P−2C−D) cycles when 0<C<P. When C=0 the low output is on for all 2P cycles. When C≥P the high output is on for all 2P cycles.
- R3: The two outputs of a pair are never on in the same cycle. After every reference transition both stay off for D cycles.
- R4: With D=0 the low output is the exact complement of the high output in every cycle.
- R5: After reset all outputs are low, the output enable and the lock are clear, and every register is zero.
- R6: Address 5 bit 0 selects the shutdown polarity (1 = active when the pin is high) and bit 1 enables shutdown. While shutdown is enabled and the pin equals the polarity bit, all six outputs are low in that same cycle.
- R7: Active shutdown clears the output enable (address 6 bit 0). After the pin is released, the outputs stay low until a 1 is written to address 6.
- R8: A write of 1 to address 6 while shutdown is active has no effect.
- R9: With shutdown disabled, the shutdown pin has no effect on the outputs.
- R10: Writing 1 to address 7 bit 0 sets the lock. Only reset clears it. While it is set, writes to addresses 4 and 5 are ignored.
- R11: While the lock is set, writes to the period, the thresholds and the output enable still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | CW | Write data |
| brk_pin | input | 1 | Shutdown request pin |
| pwm_hi | output | 3 | High-side outputs, one per channel |
| pwm_lo | output | 3 | Low-side outputs, one per channel |

## Verification
A register write is presented before a rising edge and takes effect at that edge. The counter reacts on the following cycles, and each reference and guard counter then needs up to 2P+D cycles to settle. The bench therefore waits 4P+8 cycles after any reconfiguration and only then counts on-cycles over a window of exactly 2P cycles, comparing against the closed-form counts. The shutdown pin gates the outputs combinationally, so its check samples one time step after the pin changes, with no clock edge in between.

// File: rtl/cpwm_deadband.sv
module cpwm_deadband #(
  parameter int CW  = 16,
  parameter int DTW = 8,
  parameter int NCH = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [2:0]     wr_addr,
  input  logic [CW-1:0]  wr_data,
  input  logic           brk_pin,
  output logic [NCH-1:0] pwm_hi,
  output logic [NCH-1:0] pwm_lo
);
  localparam logic [2:0] A_PER = 3'd0;
  localparam logic [2:0] A_DT  = 3'd4;
  localparam logic [2:0] A_CTL = 3'd5;
  localparam logic [2:0] A_MOE = 3'd6;
  localparam logic [2:0] A_LCK = 3'd7;

  logic [CW-1:0]  per, cnt;
  logic           cnt_up;
  logic [CW-1:0]  cmp [NCH];
  logic [DTW-1:0] dt;
  logic [DTW-1:0] dtc [NCH];
  logic           brk_pol, brk_en, moe, lock;
  logic [NCH-1:0] ref_c, ref_q, hi, lo;
  logic           brk_act;

  assign brk_act = brk_en & (brk_pin == brk_pol);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per     <= '0;
      dt      <= '0;
      brk_pol <= 1'b0;
      brk_en  <= 1'b0;
      moe     <= 1'b0;
      lock    <= 1'b0;
      for (int i = 0; i < NCH; i++) cmp[i] <= '0;
    end else begin
      if (wr_en && wr_addr == A_PER) per <= wr_data;
      for (int i = 0; i < NCH; i++)
        if (wr_en && wr_addr == 3'(i + 1)) cmp[i] <= wr_data;
      if (wr_en && wr_addr == A_DT && !lock) dt <= wr_data[DTW-1:0];
      if (wr_en && wr_addr == A_CTL && !lock) begin
        brk_pol <= wr_data[0];
        brk_en  <= wr_data[1];
      end
      if (brk_act) moe <= 1'b0;
      else if (wr_en && wr_addr == A_MOE) moe <= wr_data[0];
      if (wr_en && wr_addr == A_LCK && wr_data[0]) lock <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      cnt_up <= 1'b1;
    end else if (per == '0) begin
      cnt    <= '0;
      cnt_up <= 1'b1;
    end else if (cnt_up) begin
      if (cnt >= per - 1'b1) cnt_up <= 1'b0;
      else cnt <= cnt + 1'b1;
    end else begin
      if (cnt == '0) cnt_up <= 1'b1;
      else cnt <= cnt - 1'b1;
    end
  end

  always_comb
    for (int i = 0; i < NCH; i++) ref_c[i] = cnt < cmp[i];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= '0;
      for (int i = 0; i < NCH; i++) dtc[i] <= '0;
    end else begin
      ref_q <= ref_c;
      for (int i = 0; i < NCH; i++)
        if (ref_c[i] != ref_q[i]) dtc[i] <= dt;
        else if (dtc[i] != '0) dtc[i] <= dtc[i] - 1'b1;
    end
  end

  always_comb
    for (int i = 0; i < NCH; i++) begin
      hi[i] = ref_q[i] & (dtc[i] == '0);
      lo[i] = ~ref_q[i] & (dtc[i] == '0);
    end

  assign pwm_hi = (moe & ~brk_act) ? hi : '0;
  assign pwm_lo = (moe & ~brk_act) ? lo : '0;

  assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (per != '0 && cnt < per && !(wr_en && wr_addr == A_PER)) |=> cnt < per);
  assert_lock_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> lock);
  assert_dt_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(dt) && $stable(brk_en) && $stable(brk_pol));
  assert_brk_clears_moe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    brk_act |=> !moe);
  assert_moe_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_act && wr_en && wr_addr == A_MOE && wr_data[0]) |=> !moe);

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    assert_guard_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hi[g]) |-> ($past(!lo[g]) || $past(dt) == '0));
  end
endmodule

// File: tb/test_cpwm_deadband.sv
module test_cpwm_deadband;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        brk_pin = 1'b0;
  logic [2:0]  pwm_hi, pwm_lo;

  int n_chk = 0, n_fail = 0;
  int hc[3], lc[3];
  int both, mism, anyon;
  bit done = 0;

  always #10 clk = ~clk;

  cpwm_deadband i_cpwm_deadband (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .brk_pin(brk_pin), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic window(input int n);
    for (int c = 0; c < 3; c++) begin hc[c] = 0; lc[c] = 0; end
    both = 0; mism = 0; anyon = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk); #1;
      for (int c = 0; c < 3; c++) begin
        hc[c] += int'(pwm_hi[c]);
        lc[c] += int'(pwm_lo[c]);
        if (pwm_hi[c] && pwm_lo[c]) both++;
        if (pwm_hi[c] == pwm_lo[c]) mism++;
      end
      if (pwm_hi != 0 || pwm_lo != 0) anyon++;
    end
  endtask

  function automatic int exp_hi(int p, int c, int d);
    if (c == 0) return 0;
    if (c >= p) return 2 * p;
    return (2 * c > d) ? 2 * c - d : 0;
  endfunction

  function automatic int exp_lo(int p, int c, int d);
    if (c == 0) return 2 * p;
    if (c >= p) return 0;
    return (2 * p - 2 * c > d) ? 2 * p - 2 * c - d : 0;
  endfunction

  initial begin
    int cv[3];
    int plist[3] = '{4, 6, 8};
    repeat (3) @(negedge clk);
    #1;
    // R5: outputs low in and after reset
    check(pwm_hi == 0 && pwm_lo == 0, "R5 outputs in reset", int'({pwm_hi, pwm_lo}), 0);
    rst_n = 1'b1;
    window(4);
    check(anyon == 0, "R5 outputs after reset", anyon, 0);
    wr(6, 1);

    for (int pi = 0; pi < 3; pi++) begin
      int p = plist[pi];
      wr(0, p);
      for (int d = 0; d < 4; d++) begin
        wr(4, d);
        for (int c = 0; c <= p + 1; c++) begin
          cv[0] = c; cv[1] = (c <= p) ? p - c : 0; cv[2] = c / 2;
          for (int ch = 0; ch < 3; ch++) wr(1 + ch, cv[ch]);
          repeat (4 * p + 8) @(negedge clk);
          window(2 * p);
          for (int ch = 0; ch < 3; ch++) begin
            check(hc[ch] == exp_hi(p, cv[ch], d), "R1/R2 high-side on-count", hc[ch], exp_hi(p, cv[ch], d));
            check(lc[ch] == exp_lo(p, cv[ch], d), "R1/R2 low-side on-count", lc[ch], exp_lo(p, cv[ch], d));
          end
          check(both == 0, "R3 pair overlap", both, 0);
          if (d == 0) check(mism == 0, "R4 exact complement at zero guard", mism, 0);
        end
      end
    end

    // shutdown tests: P=8, C=4 on ch0, D=1
    wr(0, 8); wr(4, 1); wr(1, 4); wr(2, 0); wr(3, 0);
    wr(5, 3);
    repeat (40) @(negedge clk);
    window(16);
    check(hc[0] == 7, "R6 baseline before shutdown", hc[0], 7);
    @(negedge clk); brk_pin = 1'b1; #1;
    check(pwm_hi == 0 && pwm_lo == 0, "R6 same-cycle shutdown", int'({pwm_hi, pwm_lo}), 0);
    window(16);
    check(anyon == 0, "R6 held off during shutdown", anyon, 0);
    wr(6, 1);
    @(negedge clk); brk_pin = 1'b0;
    window(16);
    check(anyon == 0, "R7 R8 off after release", anyon, 0);
    wr(6, 1);
    repeat (40) @(negedge clk);
    window(16);
    check(hc[0] == 7, "R7 re-enable restores", hc[0], 7);
    // active-low polarity
    wr(5, 2);
    @(negedge clk); #1;
    check(pwm_hi == 0 && pwm_lo == 0, "R6 active-low shutdown", int'({pwm_hi, pwm_lo}), 0);
    brk_pin = 1'b1;
    wr(6, 1);
    repeat (40) @(negedge clk);
    window(16);
    check(hc[0] == 7, "R6 active-low released", hc[0], 7);
    @(negedge clk); brk_pin = 1'b0; #1;
    check(pwm_hi == 0 && pwm_lo == 0, "R6 active-low trip", int'({pwm_hi, pwm_lo}), 0);
    brk_pin = 1'b1;
    // R9: shutdown disabled
    wr(5, 1);
    wr(6, 1);
    repeat (40) @(negedge clk);
    window(16);
    check(hc[0] == 7 && lc[0] == 7, "R9 disabled shutdown ignored", hc[0], 7);
    brk_pin = 1'b0;

    // R10 lock
    wr(4, 2);
    wr(7, 1);
    wr(4, 0);
    wr(5, 3);
    wr(7, 0);
    wr(4, 0);
    repeat (40) @(negedge clk);
    window(16);
    check(hc[0] == 6, "R10 guard frozen under lock", hc[0], 6);
    @(negedge clk); brk_pin = 1'b1;
    window(16);
    check(hc[0] == 6 && lc[0] == 6, "R10 shutdown settings frozen", hc[0], 6);
    brk_pin = 1'b0;
    // R11 writable under lock
    wr(1, 2);
    repeat (40) @(negedge clk);
    window(16);
    check(hc[0] == 2, "R11 threshold write under lock", hc[0], 2);
    wr(0, 6);
    repeat (40) @(negedge clk);
    window(12);
    check(hc[0] == 2 && lc[0] == 6, "R11 period write under lock", lc[0], 6);
    wr(6, 0);
    window(12);
    check(anyon == 0, "R11 enable write under lock", anyon, 0);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule